// File: doc/BRIEF.md
# Chained Serial Converter Output Stage

This block models the digital side of one converter placed in a serial chain. Every stage's serial output drives the next stage's serial input. All conversion-start inputs are wired together, and the last stage's output goes to the host. A conversion begins on a rising edge of conversion start, and only if the serial input was low just before that edge. At that edge the stage captures its parallel sample and runs a fixed conversion of `CONV_CYC` system-clock cycles. During the conversion it holds its output low.

After the conversion the stage shifts its own word out, MSB first, on the falling edges of the serial clock. On the same edges it pulls in whatever the upstream stage presents. Once its own word is out, it relays the upstream data with no gap.

The serial-clock level at the start edge chooses between two read modes:
- **Immediate mode** (clock low): the MSB appears as soon as the conversion ends.
- **Flagged mode** (clock high): a one-bit high busy flag appears first, and the next clock fall replaces it with the MSB.

All inputs are sampled in one synchronous clock domain. The stage stays active while conversion start is held high, and a low level on conversion start returns it to idle.

Top module: `chain_adc_stage`

## Requirements
- R1: After reset `ser_out` is low and the stage is idle.
- R2: A rising edge of `conv_start` starts a conversion only if `ser_in` was low in the clock cycle before the edge is seen. If `ser_in` was high, the edge is ignored: `ser_out` stays low and serial-clock falls have no effect until `conv_start` has gone low and risen again.
- R3: `ser_out` is low for exactly `CONV_CYC` clock cycles after the clock edge that detects the start. Serial-clock activity during that time does not change the data later shifted out.
- R4: If `sclk` was low in the cycle before the start edge, then at the end of the conversion `ser_out` presents bit 15 (the MSB) of the `sample` value captured at the start edge.
- R5: If `sclk` was high in the cycle before the start edge, then at the end of the conversion `ser_out` is a high busy bit. The first later `sclk` fall replaces it with the MSB and does not capture `ser_in`.
- R6: During readout, each `sclk` fall presents the next lower bit and captures `ser_in` into the LSB end of the same register. After its own 16 bits, the stage relays the upstream words MSB first with no gap. Two stages are read with 32 falls in immediate mode and 33 in flagged mode.
- R7: `conv_start` going low at any point of a conversion or readout returns the stage to idle with `ser_out` low. The next start uses only the new sample.
- R8: A head stage whose `ser_in` is tied to `conv_start` still starts a conversion, because mode is judged on the cycle before the edge. In flagged mode it then shifts in ones after its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | Conversion start; must stay high through readout |
| sclk | input | 1 | Serial clock; falling edges shift |
| ser_in | input | 1 | Serial data from the upstream stage |
| sample | input | DATA_W | Parallel conversion result captured at start |
| ser_out | output | 1 | Serial data toward downstream stage or host |

## Verification
The bench builds a two-stage chain and streams both words through the downstream stage in each read mode. A stage that captured data during the busy fall would insert a spurious bit before the upstream word. A stage that dropped the busy flag would shift every bit one clock early. Serial-clock edges toggled during the conversion would corrupt the word if the conversion were not isolated from them. A start with a high serial input must leave the output silent, and a design that ignored the mode rule would emit a word. Dropping conversion start mid-read must silence the output, and the next read must carry only the fresh sample.

// File: rtl/chain_adc_pkg.sv
package chain_adc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_FLAG  = 2'd2,
    ST_SHIFT = 2'd3
  } stage_e;
endpackage

// File: rtl/chain_pin_sampler.sv
module chain_pin_sampler #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins,
  output logic [N-1:0] pins_prev
);
  // one history register per pin, cleared low by reset
  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n) pins_prev[i] <= 1'b0;
      else        pins_prev[i] <= pins[i];
    end
  end
endmodule

// File: rtl/chain_conv_timer.sv
module chain_conv_timer #(
  parameter int CONV_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic running,
  output logic done
);
  localparam int CW = $clog2(CONV_CYC) + 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (abort) begin
      running <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= CW'(CONV_CYC - 1);
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  assign done = running && (cnt == '0);

  // R3: countdown never exceeds the conversion length
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt < CW'(CONV_CYC)));
endmodule

// File: rtl/chain_shift_reg.sv
module chain_shift_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic              shift,
  input  logic              shift_in,
  output logic              msb
);
  logic [DATA_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= load_word;
    else if (shift) sr <= {sr[DATA_W-2:0], shift_in};
  end

  assign msb = sr[DATA_W-1];
endmodule

// File: rtl/chain_adc_stage.sv
module chain_adc_stage
  import chain_adc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CONV_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic              sclk,
  input  logic              ser_in,
  input  logic [DATA_W-1:0] sample,
  output logic              ser_out
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] pin_prev;
  logic cs_prev, sclk_prev, si_prev;

  chain_pin_sampler #(.N(NPIN)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins      ({conv_start, sclk, ser_in}),
    .pins_prev (pin_prev)
  );
  assign {cs_prev, sclk_prev, si_prev} = pin_prev;

  stage_e state;
  logic   flag_sel;
  logic   cs_rise, sclk_fall, enter, abort;
  logic   t_run, t_done, sr_msb, do_shift;

  assign cs_rise   = conv_start & ~cs_prev;
  assign sclk_fall = sclk_prev & ~sclk;
  assign abort     = (state != ST_IDLE) && !conv_start;
  // mode judged on the cycle before the edge, so a tied head stage still enters
  assign enter     = (state == ST_IDLE) && cs_rise && !si_prev;
  assign do_shift  = (state == ST_SHIFT) && sclk_fall && conv_start;

  chain_conv_timer #(.CONV_CYC(CONV_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (enter),
    .abort   (abort),
    .running (t_run),
    .done    (t_done)
  );

  chain_shift_reg #(.DATA_W(DATA_W)) u_sr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (enter),
    .load_word (sample),
    .shift     (do_shift),
    .shift_in  (ser_in),
    .msb       (sr_msb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      flag_sel <= 1'b0;
    end else if (abort) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (enter) begin
          state    <= ST_CONV;
          flag_sel <= sclk_prev;
        end
        ST_CONV:  if (t_done) state <= flag_sel ? ST_FLAG : ST_SHIFT;
        ST_FLAG:  if (sclk_fall) state <= ST_SHIFT;
        ST_SHIFT: state <= ST_SHIFT;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_FLAG:  ser_out = 1'b1;
      ST_SHIFT: ser_out = sr_msb;
      default:  ser_out = 1'b0;
    endcase
  end

  // R3: output held low while the conversion timer runs
  p_quiet_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    t_run |-> !ser_out);
  // R2: valid start launches the timer
  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cs_rise && !si_prev) |=> t_run);
  // R2: start with serial input high is ignored
  p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cs_rise && si_prev) |=> (!t_run && !ser_out));
  // R5: busy flag holds until a serial-clock fall
  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FLAG && !sclk_fall && conv_start) |=> ser_out);
  // R7: dropping conversion start silences the output
  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_start) |=> (!ser_out && !t_run));
endmodule

// File: tb/chain_adc_stage_tb.sv
module chain_adc_stage_tb;
  localparam int W  = 16;
  localparam int CC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_start = 1'b0;
  logic sclk = 1'b0;
  logic up_tie = 1'b0;
  logic ovr_en = 1'b0;
  logic ovr_val = 1'b0;
  logic [W-1:0] word_dn = '0;
  logic [W-1:0] word_up = '0;
  logic up_out, dn_out;
  logic up_si, dn_si;

  always #10 clk = ~clk;

  assign up_si = up_tie ? conv_start : 1'b0;
  assign dn_si = ovr_en ? ovr_val : up_out;

  chain_adc_stage #(.DATA_W(W), .CONV_CYC(CC)) u_up (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .sclk(sclk),
    .ser_in(up_si), .sample(word_up), .ser_out(up_out));

  chain_adc_stage #(.DATA_W(W), .CONV_CYC(CC)) u_dut (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .sclk(sclk),
    .ser_in(dn_si), .sample(word_dn), .ser_out(dn_out));

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit mon_en = 1'b0;
  logic exp_q[$];
  string mon_req = "R6";

  task automatic check(input logic act, input logic exp, input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic push_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) exp_q.push_back(w[i]);
  endtask

  // monitor: the bit presented just before each serial-clock fall
  always @(negedge sclk) begin
    if (mon_en) begin
      if (exp_q.size() == 0) check(dn_out, 1'bx, mon_req, "unexpected extra bit");
      else check(dn_out, exp_q.pop_front(), mon_req, "stream bit");
    end
  end

  task automatic clock_bits(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic stop_conv();
    @(negedge clk); conv_start = 1'b0;
    @(negedge clk); sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(dn_out, 1'b0, "R1", "output during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(dn_out, 1'b0, "R1", "output after reset");

    // immediate mode, two-stage chain (R4, R6)
    word_dn = 16'hA5C3; word_up = 16'h3C5A; up_tie = 1'b0; sclk = 1'b0;
    @(negedge clk); conv_start = 1'b1;
    repeat (CC) @(posedge clk);
    @(negedge clk); check(dn_out, 1'b0, "R3", "low in last conversion cycle");
    @(posedge clk); @(negedge clk);
    check(dn_out, 1'b1, "R4", "MSB right after conversion");
    push_word(word_dn); push_word(word_up);
    exp_q.push_back(1'b0); exp_q.push_back(1'b0);
    mon_req = "R6"; mon_en = 1'b1;
    clock_bits(34);
    mon_en = 1'b0;
    check(exp_q.size() == 0, 1'b1, "R6", "immediate stream consumed");
    stop_conv();
    check(dn_out, 1'b0, "R7", "idle after readout");

    // flagged mode, head tied to start, sclk toggled during conversion (R3, R5, R8)
    word_dn = 16'h0F1E; word_up = 16'hC381; up_tie = 1'b1;
    @(negedge clk); sclk = 1'b1;
    @(negedge clk); conv_start = 1'b1;
    repeat (2) @(negedge clk);
    for (int t = 0; t < 3; t++) begin
      sclk = 1'b0; @(negedge clk);
      check(dn_out, 1'b0, "R3", "low while converting");
      sclk = 1'b1; @(negedge clk);
    end
    repeat (CC) @(negedge clk);
    check(dn_out, 1'b1, "R5", "busy flag after conversion");
    exp_q.push_back(1'b1);
    push_word(word_dn); push_word(word_up); // R8: head stage word relayed
    exp_q.push_back(1'b1); exp_q.push_back(1'b1); // R8: head shifts in ones
    mon_req = "R5/R6/R8"; mon_en = 1'b1;
    clock_bits(35);
    mon_en = 1'b0;
    check(exp_q.size() == 0, 1'b1, "R5", "flagged stream consumed");
    stop_conv();
    up_tie = 1'b0;

    // start with serial input high is ignored (R2)
    word_dn = 16'hFFFF; ovr_en = 1'b1; ovr_val = 1'b1;
    @(negedge clk); conv_start = 1'b1;
    repeat (CC + 5) @(negedge clk);
    check(dn_out, 1'b0, "R2", "no word after ignored start");
    clock_bits(4);
    check(dn_out, 1'b0, "R2", "sclk falls ignored");
    stop_conv();
    ovr_en = 1'b0;

    // abort mid-read then fresh sample (R7)
    word_dn = 16'hF0F0; word_up = 16'h1234;
    @(negedge clk); conv_start = 1'b1;
    repeat (CC + 3) @(negedge clk);
    exp_q.push_back(1'b1); exp_q.push_back(1'b1);
    exp_q.push_back(1'b1); exp_q.push_back(1'b1);
    mon_req = "R6"; mon_en = 1'b1;
    clock_bits(4);
    mon_en = 1'b0;
    @(negedge clk); conv_start = 1'b0;
    @(negedge clk);
    check(dn_out, 1'b0, "R7", "silent after start dropped");
    repeat (3) @(negedge clk);
    word_dn = 16'h7FFF; word_up = 16'h8001;
    @(negedge clk); conv_start = 1'b1;
    repeat (CC + 3) @(negedge clk);
    check(dn_out, 1'b0, "R7", "fresh MSB of new sample");
    push_word(word_dn); push_word(word_up);
    mon_req = "R7"; mon_en = 1'b1;
    clock_bits(32);
    mon_en = 1'b0;
    check(exp_q.size() == 0, 1'b1, "R7", "fresh stream consumed");
    stop_conv();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule